// File: doc/BRIEF.md
# AUX Channel Read Retry Sequencer

This block runs a single read over a display auxiliary channel for a host. The host supplies an address space (native register space or I2C tunnelled over the channel), an address, a byte length, a middle-of-transaction flag and a per-retry pause for I2C traffic. The sequencer then drives a lower channel engine with request pulses. It takes back three things from that engine: a channel outcome, a reply code and a returned byte count.

Each response is judged against a set of independent retry budgets. These cover channel timeouts, invalid replies, short acknowledgements, native defers and I2C defers. Depending on the result, the sequencer issues the request again, continues a partial read at an advanced offset, or finishes with a final status. A finished read raises a one-cycle `done` pulse. The status stays on its output until the next read completes. Waits are counted in clock cycles through a cycles-per-microsecond parameter.

Top module: `aux_rd_seq`

## Requirements
- R1: A `start` pulse while idle makes `req_valid` rise for exactly one cycle in the next cycle, with `req_len` equal to `len`, `req_offset` 0, and `busy` high until completion.
- R2: A native read sends `addr` unchanged with command 4'b1001. An I2C read sends `addr >> 1` with command 4'b0101 when `mot` is set and 4'b0001 when it is clear.
- R3: Channel outcome timeout (code 2) reissues the request with no invalid-reply pause. The third consecutive timeout ends the read with status timeout.
- R4: Channel outcome invalid (code 1) reissues after INV_WAIT_US*CYC_PER_US extra cycles. A second invalid outcome ends the read with protocol error.
- R5: An OK outcome (code 0) whose returned count exceeds the remaining length ends the read at once with protocol error.
- R6: An ACK (reply 0) with a count below the remaining length lowers the remaining length and raises the offset by that count, then reissues. A second such short ACK ends the read with protocol error.
- R7: An ACK whose count equals the remaining length ends the read with success.
- R8: A native defer (reply 2) is retried. The seventh one without an intervening ACK or I2C defer ends with timeout. Any accepted ACK resets this budget.
- R9: An I2C defer (reply 3) is retried and resets the native-defer budget. The seventh I2C defer ends with timeout.
- R10: A NACK (reply 1) ends with status NACK. Reply codes 4 to 7, or channel outcome code 3, end with status unknown.
- R11: An OK outcome resets the timeout and invalid-reply budgets.
- R12: For I2C reads, every reissue waits an extra `i2c_gap_us`*CYC_PER_US cycles, which adds to any invalid-reply pause. Native reads ignore `i2c_gap_us`.
- R13: After reset, `status` is 0 and `done`, `busy` and `req_valid` are low. At completion `done` pulses for one cycle, and `status` holds 1 success, 2 NACK, 3 timeout, 4 protocol error or 5 unknown until the next completion.
- R14: `resp_valid` while no request is outstanding is ignored, and `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a read (taken only when idle) |
| is_i2c | input | 1 | 1 = I2C over channel, 0 = native space |
| mot | input | 1 | Middle-of-transaction flag for I2C |
| addr | input | ADDR_W | Target address |
| len | input | LEN_W | Bytes requested |
| i2c_gap_us | input | GAP_W | Extra pause before each I2C reissue, in microseconds |
| req_valid | output | 1 | One-cycle request pulse to the channel engine |
| req_cmd | output | 4 | Request command code |
| req_addr | output | ADDR_W | Address sent to the channel |
| req_len | output | LEN_W | Bytes still wanted |
| req_offset | output | LEN_W | Offset of this request in the host buffer |
| resp_valid | input | 1 | Channel response strobe |
| resp_outcome | input | 2 | 0 OK, 1 invalid, 2 timeout, 3 other |
| resp_reply | input | 3 | 0 ACK, 1 NACK, 2 native defer, 3 I2C defer, others unknown |
| resp_count | input | LEN_W | Bytes returned |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Final status code |

## Verification
A request pulse is visible one cycle after the edge that takes `start` or the triggering response. With the bench's responder, which answers one cycle after it sees a request, consecutive requests are therefore 2 cycles apart. A pause of P cycles stretches that to 2+P. The bench records the cycle of every request at the falling edge and compares the spacing with the arithmetic value. `done` and `status` are due one cycle after the terminal response. The bench samples them at the falling edge where `done` first reads high, then confirms that `done` is low one cycle later.

// File: rtl/aux_rd_pkg.sv
package aux_rd_pkg;

  typedef enum logic [1:0] {
    OUT_OK      = 2'd0,
    OUT_INVALID = 2'd1,
    OUT_TIMEOUT = 2'd2,
    OUT_OTHER   = 2'd3
  } outcome_e;

  typedef enum logic [2:0] {
    RPL_ACK       = 3'd0,
    RPL_NACK      = 3'd1,
    RPL_DEFER     = 3'd2,
    RPL_I2C_DEFER = 3'd3
  } reply_e;

  typedef enum logic [2:0] {
    ST_NONE    = 3'd0,
    ST_OK      = 3'd1,
    ST_NACK    = 3'd2,
    ST_TIMEOUT = 3'd3,
    ST_PROTO   = 3'd4,
    ST_UNKNOWN = 3'd5
  } status_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WAIT  = 2'd1,
    SQ_PAUSE = 2'd2
  } seq_state_e;

  localparam logic [3:0] CMD_NATIVE_RD  = 4'b1001;
  localparam logic [3:0] CMD_I2C_RD     = 4'b0001;
  localparam logic [3:0] CMD_I2C_RD_MOT = 4'b0101;

  localparam int NUM_BUDGETS = 5;
  localparam int B_TMO    = 0;
  localparam int B_INV    = 1;
  localparam int B_SHORT  = 2;
  localparam int B_DEF    = 3;
  localparam int B_I2CDEF = 4;

endpackage

// File: rtl/aux_rd_budget.sv
module aux_rd_budget #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic spent,
  output logic empty
);
  localparam int CW = $clog2(LIMIT + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt <= CW'(LIMIT))) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign spent = (cnt >= CW'(LIMIT));
  assign empty = (cnt == '0);

  // the sequencer must end the read rather than count past the limit
  AST_NO_INC_PAST_LIMIT: assert property (@(posedge clk) disable iff (rst)
    !(inc && spent)); // R8

endmodule

// File: rtl/aux_rd_pause.sv
module aux_rd_pause #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] cycles,
  output logic          active,
  output logic          fire
);
  logic [TW-1:0] timer;

  always_ff @(posedge clk) begin
    if (rst) begin
      timer <= '0;
    end else if (load) begin
      timer <= cycles;
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  assign active = (timer != '0);
  assign fire   = (timer == TW'(1));

endmodule

// File: rtl/aux_rd_seq.sv
module aux_rd_seq
  import aux_rd_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int LEN_W       = 5,
  parameter int GAP_W       = 8,
  parameter int CYC_PER_US  = 100,
  parameter int INV_WAIT_US = 400,
  parameter int TMO_LIMIT   = 2,
  parameter int INV_LIMIT   = 1,
  parameter int SHORT_LIMIT = 1,
  parameter int DEFER_LIMIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_i2c,
  input  logic              mot,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [GAP_W-1:0]  i2c_gap_us,
  output logic              req_valid,
  output logic [3:0]        req_cmd,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [LEN_W-1:0]  req_offset,
  input  logic              resp_valid,
  input  logic [1:0]        resp_outcome,
  input  logic [2:0]        resp_reply,
  input  logic [LEN_W-1:0]  resp_count,
  output logic              busy,
  output logic              done,
  output logic [2:0]        status
);
  localparam int PUS_MAX = INV_WAIT_US + (2 ** GAP_W) - 1;
  localparam int TW      = $clog2(PUS_MAX * CYC_PER_US + 2);

  function automatic int budget_limit(input int idx);
    case (idx)
      B_TMO:   return TMO_LIMIT;
      B_INV:   return INV_LIMIT;
      B_SHORT: return SHORT_LIMIT;
      default: return DEFER_LIMIT;
    endcase
  endfunction

  seq_state_e          state;
  logic [LEN_W-1:0]    rem_q, off_q, len_q;
  logic                i2c_q;
  logic [GAP_W-1:0]    gap_q;

  logic                accept;
  logic                fin;
  status_e             fin_st;
  logic                adv;
  logic                wait_inv;
  logic [NUM_BUDGETS-1:0] b_inc, b_clr, b_spent, b_empty;
  logic [LEN_W-1:0]    next_rem, next_off;
  logic [TW-1:0]       pause_cyc;
  logic                p_load, p_active, p_fire;

  // one retry budget per failure class
  for (genvar g = 0; g < NUM_BUDGETS; g++) begin : g_budget
    aux_rd_budget #(.LIMIT(budget_limit(g))) u_budget (
      .clk   (clk),
      .rst   (rst),
      .clr   (b_clr[g]),
      .inc   (b_inc[g]),
      .spent (b_spent[g]),
      .empty (b_empty[g])
    );
  end

  aux_rd_pause #(.TW(TW)) u_pause (
    .clk    (clk),
    .rst    (rst),
    .load   (p_load),
    .cycles (pause_cyc),
    .active (p_active),
    .fire   (p_fire)
  );

  assign accept = resp_valid && (state == SQ_WAIT);

  // response judgement
  always_comb begin
    fin      = 1'b0;
    fin_st   = ST_NONE;
    adv      = 1'b0;
    wait_inv = 1'b0;
    b_inc    = '0;
    b_clr    = '0;
    if (state == SQ_IDLE && start) begin
      b_clr = '1;
    end else if (accept) begin
      case (outcome_e'(resp_outcome))
        OUT_OK: begin
          if (resp_count > rem_q) begin
            fin    = 1'b1;
            fin_st = ST_PROTO;
          end else begin
            b_clr[B_TMO] = 1'b1;
            b_clr[B_INV] = 1'b1;
            case (resp_reply)
              RPL_ACK: begin
                b_clr[B_DEF] = 1'b1;
                if (resp_count == rem_q) begin
                  fin    = 1'b1;
                  fin_st = ST_OK;
                end else if (b_spent[B_SHORT]) begin
                  fin    = 1'b1;
                  fin_st = ST_PROTO;
                end else begin
                  adv            = 1'b1;
                  b_inc[B_SHORT] = 1'b1;
                end
              end
              RPL_NACK: begin
                fin    = 1'b1;
                fin_st = ST_NACK;
              end
              RPL_DEFER: begin
                if (b_spent[B_DEF]) begin
                  fin    = 1'b1;
                  fin_st = ST_TIMEOUT;
                end else begin
                  b_inc[B_DEF] = 1'b1;
                end
              end
              RPL_I2C_DEFER: begin
                b_clr[B_DEF] = 1'b1;
                if (b_spent[B_I2CDEF]) begin
                  fin    = 1'b1;
                  fin_st = ST_TIMEOUT;
                end else begin
                  b_inc[B_I2CDEF] = 1'b1;
                end
              end
              default: begin
                fin    = 1'b1;
                fin_st = ST_UNKNOWN;
              end
            endcase
          end
        end
        OUT_INVALID: begin
          if (b_spent[B_INV]) begin
            fin    = 1'b1;
            fin_st = ST_PROTO;
          end else begin
            b_inc[B_INV] = 1'b1;
            wait_inv     = 1'b1;
          end
        end
        OUT_TIMEOUT: begin
          if (b_spent[B_TMO]) begin
            fin    = 1'b1;
            fin_st = ST_TIMEOUT;
          end else begin
            b_inc[B_TMO] = 1'b1;
          end
        end
        default: begin
          fin    = 1'b1;
          fin_st = ST_UNKNOWN;
        end
      endcase
    end
  end

  always_comb begin
    next_rem  = adv ? (rem_q - resp_count) : rem_q;
    next_off  = adv ? (off_q + resp_count) : off_q;
    pause_cyc = TW'(((wait_inv ? INV_WAIT_US : 0) + (i2c_q ? int'(gap_q) : 0)) * CYC_PER_US);
    p_load    = accept && !fin && (pause_cyc != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      rem_q      <= '0;
      off_q      <= '0;
      len_q      <= '0;
      i2c_q      <= 1'b0;
      gap_q      <= '0;
      req_valid  <= 1'b0;
      req_cmd    <= '0;
      req_addr   <= '0;
      req_len    <= '0;
      req_offset <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      status     <= ST_NONE;
    end else begin
      req_valid <= 1'b0;
      done      <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            rem_q      <= len;
            off_q      <= '0;
            len_q      <= len;
            i2c_q      <= is_i2c;
            gap_q      <= i2c_gap_us;
            req_valid  <= 1'b1;
            req_len    <= len;
            req_offset <= '0;
            req_addr   <= is_i2c ? (addr >> 1) : addr;
            req_cmd    <= !is_i2c ? CMD_NATIVE_RD : (mot ? CMD_I2C_RD_MOT : CMD_I2C_RD);
            busy       <= 1'b1;
            state      <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (accept) begin
            if (fin) begin
              done   <= 1'b1;
              status <= fin_st;
              busy   <= 1'b0;
              state  <= SQ_IDLE;
            end else begin
              rem_q <= next_rem;
              off_q <= next_off;
              if (p_load) begin
                state <= SQ_PAUSE;
              end else begin
                req_valid  <= 1'b1;
                req_len    <= next_rem;
                req_offset <= next_off;
              end
            end
          end
        end
        SQ_PAUSE: begin
          if (p_fire) begin
            req_valid  <= 1'b1;
            req_len    <= rem_q;
            req_offset <= off_q;
            state      <= SQ_WAIT;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // assertions
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid); // R1

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R13

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && (status != ST_NONE)); // R13

  AST_SPAN_FIXED: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ({1'b0, req_offset} + {1'b0, req_len}) == {1'b0, len_q}); // R6

  AST_OVERRUN_PROTO: assert property (@(posedge clk) disable iff (rst)
    (accept && resp_outcome == OUT_OK && resp_count > rem_q) |=> done && status == ST_PROTO); // R5

  AST_NACK_FINAL: assert property (@(posedge clk) disable iff (rst)
    (accept && resp_outcome == OUT_OK && resp_count <= rem_q && resp_reply == RPL_NACK)
      |=> done && status == ST_NACK); // R10

  AST_ACK_CLEARS_DEFER: assert property (@(posedge clk) disable iff (rst)
    (accept && !fin && resp_outcome == OUT_OK && resp_reply == RPL_ACK) |=> b_empty[B_DEF]); // R8

  AST_I2CDEF_CLEARS_DEFER: assert property (@(posedge clk) disable iff (rst)
    (accept && !fin && resp_outcome == OUT_OK && resp_reply == RPL_I2C_DEFER) |=> b_empty[B_DEF]); // R9

  AST_OK_CLEARS_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    (accept && !fin && resp_outcome == OUT_OK) |=> b_empty[B_TMO] && b_empty[B_INV]); // R11

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_PAUSE && p_active && !p_fire) |=> !req_valid); // R12

endmodule

// File: tb/aux_rd_seq_tb.sv
module aux_rd_seq_tb;
  localparam int PERIOD = 10;
  localparam int AW  = 12;
  localparam int LW  = 5;
  localparam int GW  = 4;
  localparam int CPU = 2;
  localparam int INV = 5;

  logic clk = 0;
  logic rst = 1;
  logic start = 0, is_i2c = 0, mot = 0;
  logic [AW-1:0] addr = '0;
  logic [LW-1:0] len = '0;
  logic [GW-1:0] gap = '0;
  logic req_valid;
  logic [3:0] req_cmd;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len, req_offset;
  logic rv = 0;
  logic [1:0] r_outc = 0;
  logic [2:0] r_repl = 0;
  logic [LW-1:0] r_cnt = 0;
  logic busy, done;
  logic [2:0] status;

  aux_rd_seq #(.ADDR_W(AW), .LEN_W(LW), .GAP_W(GW), .CYC_PER_US(CPU), .INV_WAIT_US(INV)) u_dut (
    .clk(clk), .rst(rst), .start(start), .is_i2c(is_i2c), .mot(mot), .addr(addr), .len(len),
    .i2c_gap_us(gap), .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_len(req_len), .req_offset(req_offset), .resp_valid(rv), .resp_outcome(r_outc),
    .resp_reply(r_repl), .resp_count(r_cnt), .busy(busy), .done(done), .status(status));

  always #(PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int s_out [64], s_rpl [64], s_cnt [64];
  int q_len [64], q_off [64], q_cmd [64], q_addr [64], q_t [64];
  int idx = 0;
  bit pend = 0;
  bit quiet = 0;

  // channel model: answers one cycle after seeing a request
  initial begin
    forever begin
      @(negedge clk);
      if (!quiet) begin
        if (rv) rv = 0;
        if (pend) begin
          r_outc = s_out[idx-1][1:0];
          r_repl = s_rpl[idx-1][2:0];
          r_cnt  = s_cnt[idx-1][LW-1:0];
          rv = 1;
          pend = 0;
        end
        if (req_valid && idx < 64) begin
          q_len[idx] = req_len; q_off[idx] = req_offset;
          q_cmd[idx] = req_cmd; q_addr[idx] = req_addr; q_t[idx] = cyc;
          idx = idx + 1;
          pend = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic put(input int i, input int o, input int r, input int c);
    s_out[i] = o; s_rpl[i] = r; s_cnt[i] = c;
  endtask

  int st_r, nreq_r;

  task automatic run(input bit i2c, input bit m, input int a, input int l, input int g, input int hold);
    int waited;
    idx = 0; pend = 0;
    @(negedge clk);
    is_i2c = i2c; mot = m; addr = AW'(a); len = LW'(l); gap = GW'(g);
    start = 1;
    for (int k = 0; k < hold; k++) @(negedge clk);
    start = 0;
    waited = 0;
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    st_r = status;
    nreq_r = idx;
    chk(done == 1, "R13 done seen", done, 1);
    @(negedge clk);
    chk(done == 0 && busy == 0, "R13 done one cycle", done, 0);
  endtask

  // k retries of one kind, then a full ACK
  task automatic retry_sweep(input bit i2c, input int o, input int r, input int k, input int l);
    for (int i = 0; i < k; i++) put(i, o, r, 0);
    put(k, 0, 0, l);
    run(i2c, 1, 'h40, l, 0, 1);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13 reset state
    chk(status == 0 && !done && !busy && !req_valid, "R13 reset", status, 0);

    // R1 R2 native
    put(0, 0, 0, 8);
    run(0, 0, 'h123, 8, 3, 1);
    chk(st_r == 1, "R7 native ok", st_r, 1);
    chk(nreq_r == 1, "R1 one request", nreq_r, 1);
    chk(q_cmd[0] == 9, "R2 native cmd", q_cmd[0], 9);
    chk(q_addr[0] == 'h123, "R2 native addr", q_addr[0], 'h123);
    chk(q_len[0] == 8 && q_off[0] == 0, "R1 first len/off", q_len[0], 8);

    // R2 I2C with and without MOT
    for (int m = 0; m < 2; m++) begin
      put(0, 0, 0, 3);
      run(1, m[0], 'h0A7, 3, 0, 1);
      chk(q_addr[0] == 'h053, "R2 i2c addr", q_addr[0], 'h053);
      chk(q_cmd[0] == (m ? 5 : 1), "R2 i2c cmd", q_cmd[0], m ? 5 : 1);
    end

    // R7 full ACK over all lengths
    for (int l = 0; l < 32; l++) begin
      put(0, 0, 0, l);
      run(l[0], 0, l, l, 0, 1);
      chk(st_r == 1 && nreq_r == 1, "R7 full ack", st_r, 1);
    end

    // R5 overrun
    for (int l = 0; l < 9; l++) begin
      put(0, 0, 0, l + 1);
      run(0, 0, 1, l, 0, 1);
      chk(st_r == 4 && nreq_r == 1, "R5 overrun", st_r, 4);
    end

    // R6 one short ACK then completion, every split
    for (int l = 1; l < 7; l++) begin
      for (int c = 0; c < l; c++) begin
        put(0, 0, 0, c);
        put(1, 0, 0, l - c);
        run(0, 0, 2, l, 0, 1);
        chk(st_r == 1 && nreq_r == 2, "R6 short then ok", st_r, 1);
        chk(q_len[1] == l - c && q_off[1] == c, "R6 continuation", q_off[1], c);
      end
    end
    // R6 two short ACKs
    put(0, 0, 0, 1); put(1, 0, 0, 1); put(2, 0, 0, 4);
    run(0, 0, 2, 6, 0, 1);
    chk(st_r == 4 && nreq_r == 2, "R6 second short", st_r, 4);

    // R3 timeouts
    for (int k = 0; k < 5; k++) begin
      retry_sweep(0, 2, 0, k, 4);
      chk(st_r == (k <= 2 ? 1 : 3), "R3 timeout budget", st_r, k <= 2 ? 1 : 3);
      chk(nreq_r == (k <= 2 ? k + 1 : 3), "R3 request count", nreq_r, k <= 2 ? k + 1 : 3);
    end
    chk(q_t[1] - q_t[0] == 2, "R3 no pause", q_t[1] - q_t[0], 2);

    // R4 invalid replies
    for (int k = 0; k < 4; k++) begin
      retry_sweep(0, 1, 0, k, 4);
      chk(st_r == (k <= 1 ? 1 : 4), "R4 invalid budget", st_r, k <= 1 ? 1 : 4);
      chk(nreq_r == (k <= 1 ? k + 1 : 2), "R4 request count", nreq_r, k <= 1 ? k + 1 : 2);
    end
    chk(q_t[1] - q_t[0] == 2 + INV * CPU, "R4 pause", q_t[1] - q_t[0], 2 + INV * CPU);

    // R8 native defers
    for (int k = 0; k < 9; k++) begin
      retry_sweep(0, 0, 2, k, 3);
      chk(st_r == (k <= 6 ? 1 : 3), "R8 defer budget", st_r, k <= 6 ? 1 : 3);
      chk(nreq_r == (k <= 6 ? k + 1 : 7), "R8 request count", nreq_r, k <= 6 ? k + 1 : 7);
    end
    // R8 ACK resets defer budget: 6 defers, short ACK, 6 defers, ACK
    for (int i = 0; i < 6; i++) put(i, 0, 2, 0);
    put(6, 0, 0, 1);
    for (int i = 7; i < 13; i++) put(i, 0, 2, 0);
    put(13, 0, 0, 3);
    run(0, 0, 5, 4, 0, 1);
    chk(st_r == 1 && nreq_r == 14, "R8 ack clears defer", st_r, 1);

    // R9 I2C defers
    for (int k = 0; k < 9; k++) begin
      retry_sweep(1, 0, 3, k, 3);
      chk(st_r == (k <= 6 ? 1 : 3), "R9 i2c defer budget", st_r, k <= 6 ? 1 : 3);
    end
    for (int i = 0; i < 6; i++) put(i, 0, 2, 0);
    put(6, 0, 3, 0);
    for (int i = 7; i < 13; i++) put(i, 0, 2, 0);
    put(13, 0, 0, 2);
    run(1, 0, 5, 2, 0, 1);
    chk(st_r == 1 && nreq_r == 14, "R9 i2c defer clears defer", st_r, 1);

    // R10 NACK and unknown codes
    put(0, 0, 1, 0);
    run(0, 0, 1, 4, 0, 1);
    chk(st_r == 2, "R10 nack", st_r, 2);
    for (int r = 4; r < 8; r++) begin
      put(0, 0, r, 0);
      run(0, 0, 1, 4, 0, 1);
      chk(st_r == 5, "R10 unknown reply", st_r, 5);
    end
    put(0, 3, 0, 0);
    run(0, 0, 1, 4, 0, 1);
    chk(st_r == 5 && nreq_r == 1, "R10 unknown outcome", st_r, 5);

    // R11 OK outcome resets timeout and invalid budgets
    put(0, 2, 0, 0); put(1, 2, 0, 0); put(2, 0, 0, 1);
    put(3, 2, 0, 0); put(4, 2, 0, 0); put(5, 0, 0, 3);
    run(0, 0, 1, 4, 0, 1);
    chk(st_r == 1 && nreq_r == 6, "R11 timeout reset", st_r, 1);
    put(0, 1, 0, 0); put(1, 0, 2, 0); put(2, 1, 0, 0); put(3, 0, 0, 4);
    run(0, 0, 1, 4, 0, 1);
    chk(st_r == 1 && nreq_r == 4, "R11 invalid reset", st_r, 1);

    // R12 I2C gap
    put(0, 2, 0, 0); put(1, 0, 0, 2);
    run(1, 1, 8, 2, 3, 1);
    chk(q_t[1] - q_t[0] == 2 + 3 * CPU, "R12 i2c gap", q_t[1] - q_t[0], 2 + 3 * CPU);
    put(0, 1, 0, 0); put(1, 0, 0, 2);
    run(1, 1, 8, 2, 3, 1);
    chk(q_t[1] - q_t[0] == 2 + (INV + 3) * CPU, "R12 gap plus invalid", q_t[1] - q_t[0], 2 + (INV + 3) * CPU);
    put(0, 2, 0, 0); put(1, 0, 0, 2);
    run(0, 1, 8, 2, 3, 1);
    chk(q_t[1] - q_t[0] == 2, "R12 native ignores gap", q_t[1] - q_t[0], 2);

    // R14 stray response while idle
    quiet = 1;
    @(negedge clk);
    r_outc = 0; r_repl = 1; r_cnt = 0; rv = 1;
    @(negedge clk);
    rv = 0;
    repeat (3) begin
      @(negedge clk);
      chk(!done && !busy && !req_valid && status == 1, "R14 stray response", status, 1);
    end
    quiet = 0;
    // R14 start held while busy
    put(0, 0, 0, 4);
    run(0, 0, 1, 4, 0, 3);
    chk(nreq_r == 1 && st_r == 1, "R14 start while busy", nreq_r, 1);
    repeat (4) @(negedge clk);
    chk(idx == 1 && !busy, "R14 no second read", idx, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule